// File: doc/BRIEF.md
# Contiguous-Region Leaf Entry Fixup Stage

This block is one registered pipeline stage at the tail of a three-level page-table walk with 39-bit virtual addresses. It receives the leaf page-table entry the walker found, the walk level at which it was found (0 is the 4 KiB level) and the virtual page number being translated. It returns a possibly rewritten entry, a region-size code and a page-fault flag.

Entries whose contiguity flag (bit 63) is clear pass through untouched. When the flag is set, the stage inspects the low bits of the level-0 frame field. A single set bit at position 3 with zeros below it marks a 64 KiB naturally aligned region. In that case the four low frame bits are taken from the virtual page number, so the entry maps exactly the 4 KiB page being translated. Any other pattern, or the flag appearing at level 1 or 2, is a reserved encoding: the stage raises a fault and clears the entry's valid bit.

The stage uses a valid/ready handshake on both sides. A result is registered one cycle after its input is accepted, and it is held until the consumer takes it.

Top module: `leaf_contig_fixup`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With entry bit 63 equal to 0, the output entry equals the input entry bit for bit, `out_size` is 0 and `out_fault` is 0, whatever the level.
- R3: With bit 63 equal to 1, level 0 and entry bits 13:10 (low four bits of the level-0 frame field, which sits at bits 18:10) equal to 4'b1000, `out_size` is 1 and `out_fault` is 0.
- R4: In the R3 case the output entry equals the input entry except that bits 13:10 are replaced by `in_vpn[3:0]`; every other bit, bit 63 included, is unchanged.
- R5: With bit 63 equal to 1, level 0 and bits 13:10 different from 4'b1000, `out_fault` is 1, `out_size` is 0, and the output entry is the input with bit 0 (valid) forced to 0.
- R6: With bit 63 equal to 1 and level 1, 2 or 3, the result is a fault as in R5, even when bits 13:10 equal 4'b1000.
- R7: An input accepted on a clock edge (`in_valid` and `in_ready` both 1) produces `out_valid` equal to 1 after that same edge, so the result is visible in the following cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pte`, `out_size` and `out_fault` keep their values.
- R9: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. A result can therefore be drained and a new input accepted on the same edge, which gives one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input entry present |
| in_ready | output | 1 | Stage can take an input this cycle |
| in_pte | input | 64 | Leaf page-table entry |
| in_level | input | 2 | Walk level the entry came from |
| in_vpn | input | 27 | Virtual page number being translated |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pte | output | 64 | Corrected entry |
| out_size | output | 1 | 0: base page or plain entry, 1: 64 KiB region |
| out_fault | output | 1 | Reserved contiguous encoding, page fault |

## Verification
Draining a held result and capturing a new entry can fall on the same edge. This is the case where a lost or duplicated result would show up. The bench provokes it by streaming a long mix of plain, region and reserved entries while `out_ready` toggles pseudo-randomly. The result queue is judged in order, so every result must come out exactly once with the fields its own input predicts, and any result held during a stall must not change.

// File: rtl/napot_pkg.sv
package napot_pkg;

    localparam int PTE_W      = 64;
    localparam int LVL_W      = 2;
    localparam int VPN_W      = 27;
    localparam int FRAME_LSB  = 10;   // level-0 frame field starts here
    localparam int CONTIG_BIT = 63;   // contiguity flag
    localparam int NAPOT_BITS = 4;    // 64 KiB = 16 base pages

    localparam logic [NAPOT_BITS-1:0] REGION_CODE =
        {1'b1, {(NAPOT_BITS-1){1'b0}}};

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_REGION = 2'd1,
        KIND_FAULT  = 2'd2
    } entry_kind_e;

    typedef enum logic {
        SZ_BASE   = 1'b0,
        SZ_REGION = 1'b1
    } size_code_e;

    typedef struct packed {
        logic [PTE_W-1:0] pte;
        size_code_e       size;
        logic             fault;
    } fixup_res_t;

    function automatic logic low_bits_mark_region(input logic [NAPOT_BITS-1:0] low);
        return low == REGION_CODE;
    endfunction

endpackage

// File: rtl/napot_classify.sv
module napot_classify
    import napot_pkg::*;
(
    input  logic                  contig,
    input  logic [LVL_W-1:0]      level,
    input  logic [NAPOT_BITS-1:0] frame_low,
    output entry_kind_e           kind
);
    always_comb begin
        if (!contig)
            kind = KIND_PLAIN;
        else if (level == '0 && low_bits_mark_region(frame_low))
            kind = KIND_REGION;
        else
            kind = KIND_FAULT;
    end
endmodule

// File: rtl/napot_rewrite.sv
module napot_rewrite
    import napot_pkg::*;
(
    input  logic [PTE_W-1:0]      pte_in,
    input  logic [NAPOT_BITS-1:0] vpn_low,
    input  entry_kind_e           kind,
    output fixup_res_t            res
);
    logic [PTE_W-1:0] spliced;

    // Replace the low frame bits one by one from the virtual page number.
    for (genvar b = 0; b < PTE_W; b++) begin : g_bit
        if (b >= FRAME_LSB && b < FRAME_LSB + NAPOT_BITS) begin : g_low
            assign spliced[b] = vpn_low[b - FRAME_LSB];
        end else begin : g_keep
            assign spliced[b] = pte_in[b];
        end
    end

    always_comb begin
        res = '{pte: pte_in, size: SZ_BASE, fault: 1'b0};
        unique case (kind)
            KIND_REGION: begin
                res.pte  = spliced;
                res.size = SZ_REGION;
            end
            KIND_FAULT: begin
                res.pte[0] = 1'b0;
                res.fault  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/napot_out_reg.sv
module napot_out_reg
    import napot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       d_valid,
    output logic       d_ready,
    input  fixup_res_t d,
    output logic       q_valid,
    input  logic       q_ready,
    output fixup_res_t q
);
    assign d_ready = !q_valid || q_ready;

    always_ff @(posedge clk) begin
        if (rst)
            q_valid <= 1'b0;
        else if (d_ready)
            q_valid <= d_valid;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (d_valid && d_ready)
            q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        q_valid && !q_ready |=> q_valid && $stable(q)) else $error("hold"); // R8

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        d_valid && d_ready |=> q_valid) else $error("latency"); // R7
endmodule

// File: rtl/leaf_contig_fixup.sv
module leaf_contig_fixup
    import napot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      in_pte,
    input  logic [1:0]       in_level,
    input  logic [26:0]      in_vpn,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_pte,
    output logic             out_size,
    output logic             out_fault
);
    entry_kind_e kind;
    fixup_res_t  comb_res;
    fixup_res_t  reg_res;

    napot_classify u_classify (
        .contig    (in_pte[CONTIG_BIT]),
        .level     (in_level),
        .frame_low (in_pte[FRAME_LSB +: NAPOT_BITS]),
        .kind      (kind)
    );

    napot_rewrite u_rewrite (
        .pte_in  (in_pte),
        .vpn_low (in_vpn[NAPOT_BITS-1:0]),
        .kind    (kind),
        .res     (comb_res)
    );

    napot_out_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_ready (in_ready),
        .d       (comb_res),
        .q_valid (out_valid),
        .q_ready (out_ready),
        .q       (reg_res)
    );

    assign out_pte   = reg_res.pte;
    assign out_size  = reg_res.size;
    assign out_fault = reg_res.fault;

    AST_FAULT_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fault |-> !out_pte[0]) else $error("fault v"); // R5

    AST_REGION_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_size |-> !out_fault && out_pte[CONTIG_BIT]) else $error("region"); // R3

    AST_PLAIN_UNMARKED: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_pte[CONTIG_BIT] |-> !out_fault && !out_size) else $error("plain"); // R2
endmodule

// File: tb/leaf_contig_fixup_tb.sv
module leaf_contig_fixup_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_pte = '0;
    logic [1:0]  in_level = '0;
    logic [26:0] in_vpn = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_pte;
    logic        out_size;
    logic        out_fault;

    typedef struct {
        logic [63:0] pte;
        logic        size;
        logic        fault;
        string       req;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   stall_mode = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    leaf_contig_fixup u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_pte(in_pte), .in_level(in_level), .in_vpn(in_vpn),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pte(out_pte), .out_size(out_size), .out_fault(out_fault)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic exp_t model(input logic [63:0] p, input logic [1:0] lvl, input logic [26:0] v);
        exp_t e;
        e.pte = p; e.size = 1'b0; e.fault = 1'b0;
        if (!p[63]) begin
            e.req = "R2";
        end else if (lvl != 2'd0) begin
            e.pte[0] = 1'b0; e.fault = 1'b1; e.req = "R6";
        end else if (p[13:10] != 4'b1000) begin
            e.pte[0] = 1'b0; e.fault = 1'b1; e.req = "R5";
        end else begin
            e.pte[13:10] = v[3:0]; e.size = 1'b1; e.req = "R3/R4";
        end
        return e;
    endfunction

    // Driver: presents one entry, waits for acceptance, queues the expectation.
    task automatic send(input logic [63:0] p, input logic [1:0] lvl, input logic [26:0] v, input bit chk_lat);
        @(negedge clk);
        in_valid = 1'b1; in_pte = p; in_level = lvl; in_vpn = v;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        expq.push_back(model(p, lvl, v));
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (chk_lat)  // R7
            check(out_valid == 1'b1, "R7 latency", {127'd0, out_valid}, 128'd1);
    endtask

    // Consumer ready pattern.
    always @(negedge clk) begin
        if (stall_mode) out_ready <= ($urandom % 3) != 0;
        else            out_ready <= 1'b1;
    end

    // Monitor: handshake rule, hold stability, scoreboard compare.
    logic [65:0] held;
    bit          was_stalled = 1'b0;
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            exp_t e;
            check(in_ready == (!out_valid || out_ready), "R9 in_ready",
                  {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
            if (was_stalled)
                check(out_valid && {out_pte, out_size, out_fault} == held, "R8 hold",
                      {61'd0, out_valid, out_pte, out_size, out_fault}, {61'd0, 1'b1, held});
            was_stalled = out_valid && !out_ready;
            held = {out_pte, out_size, out_fault};
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 extra result", {64'd0, out_pte}, 128'd0);
                end else begin
                    e = expq.pop_front();
                    check({out_pte, out_size, out_fault} == {e.pte, e.size, e.fault}, e.req,
                          {62'd0, out_pte, out_size, out_fault}, {62'd0, e.pte, e.size, e.fault});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expected=done actual=hung");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        logic [63:0] base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", {127'd0, out_valid}, 128'd0);
        check(in_ready == 1'b1, "R1 in_ready", {127'd0, in_ready}, 128'd1);

        base = 64'h0000_1234_5678_9ABF;
        // R2 plain entries at each level, including a 1000 frame pattern
        send(base & ~(64'd1 << 63), 2'd0, 27'h1_2345, 1'b1);
        send(64'h0000_0000_0000_2001, 2'd2, 27'h7_FFFF, 1'b0);
        send({1'b0, base[62:14], 4'b1000, base[9:0]}, 2'd1, 27'h0_000F, 1'b0);
        // R3/R4 region at level 0 with several vpn patterns
        send({1'b1, base[62:14], 4'b1000, base[9:0]}, 2'd0, 27'h5_5555, 1'b1);
        send({1'b1, 49'd0, 4'b1000, 10'h0CF}, 2'd0, 27'h7_FFF0, 1'b0);
        send({1'b1, {49{1'b1}}, 4'b1000, 10'h3FF}, 2'd0, 27'h0_000F, 1'b0);
        // R5 reserved low patterns at level 0
        send({1'b1, base[62:14], 4'b0001, base[9:0]}, 2'd0, 27'h1, 1'b0);
        send({1'b1, base[62:14], 4'b0010, base[9:0]}, 2'd0, 27'h2, 1'b0);
        send({1'b1, base[62:14], 4'b0100, base[9:0]}, 2'd0, 27'h3, 1'b0);
        send({1'b1, base[62:14], 4'b0000, base[9:0]}, 2'd0, 27'h4, 1'b0);
        send({1'b1, base[62:14], 4'b1001, base[9:0]}, 2'd0, 27'h5, 1'b0);
        send({1'b1, base[62:14], 4'b1100, base[9:0]}, 2'd0, 27'h6, 1'b0);
        // R6 flag at upper levels, even with the region pattern
        send({1'b1, base[62:14], 4'b1000, base[9:0]}, 2'd1, 27'h7, 1'b0);
        send({1'b1, base[62:14], 4'b1000, base[9:0]}, 2'd2, 27'h8, 1'b0);
        send({1'b1, base[62:14], 4'b1000, base[9:0]}, 2'd3, 27'h9, 1'b0);

        // Streaming under random back-pressure: R8, R9 and the mixed cases
        stall_mode = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] p;
            p = rnd64();
            if (($urandom % 2) == 0) p[13:10] = 4'b1000;
            send(p, 2'($urandom % 4), 27'($urandom), 1'b0);
        end
        // Back-to-back with consumer always ready
        stall_mode = 1'b0;
        for (int i = 0; i < 50; i++) begin
            logic [63:0] p;
            p = rnd64();
            p[63] = 1'b1; p[13:10] = 4'b1000;
            send(p, 2'd0, 27'($urandom), 1'b0);
        end

        for (int k = 0; k < 50 && expq.size() != 0; k++) @(posedge clk);
        check(expq.size() == 0, "R9 all drained", 128'(expq.size()), 128'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule